// File: doc/BRIEF.md
# Serial EEPROM command engine

This block interprets the byte-level command stream of a 32K x 8 class serial EEPROM and carries each command out against a behavioural byte array. A serial front end, outside this block, turns pin activity into single-cycle events: select asserted, select released (with a flag that says whether the release fell exactly after a whole byte), one received byte, and one request for the next outgoing byte. The engine answers with a byte to shift out and a flag that says an outgoing byte is meaningful.

It supports setting and clearing the write-enable latch, reading and writing the status byte, streaming reads with an address that wraps across the whole array, and page writes that are collected in a page buffer and committed to the array during a self-timed busy period. A protection checker rules on every modifying command: array writes against the block-protect level, status writes against the hardware protect pin combined with the protect-enable bit. The array depth, the page size and the busy length in clock cycles are parameters; `WR_CYCLES` must be at least the page size, because the buffered page is copied into the array one byte per cycle while busy.

Top module: `eep_cmd_engine`

## Requirements
- R1: The first byte after select is the opcode. With bit 3 ignored and bits 7..4 required to be zero: 0x06 sets the latch, 0x04 clears it, 0x05 reads status, 0x01 writes status, 0x03 reads, 0x02 writes. Any other value, and every byte after a one-byte command, is ignored until the next select.
- R2: After reset the status byte is 0x00. Its layout is bit 7 protect-enable, bits 3:2 block-protect level, bit 1 write-enable latch, bit 0 busy, bits 6:4 zero.
- R3: While busy, a status read returns 0xFF and every other opcode, including latch changes, is ignored for that select.
- R4: Read and write take two address bytes, high byte first; address bits at and above `ADDR_W` are ignored. A read returns successive bytes, one per byte request, and wraps from the last location to 0.
- R5: A write or status write issued while the latch is clear changes nothing and starts no busy period.
- R6: Write data lands at successive columns of the addressed page; the column wraps at the page end while the page bits stay fixed, so a later byte overwrites an earlier one at the same column.
- R7: A write or status write commits only when select is released with the aligned flag set after at least one data byte; otherwise it is dropped, the latch keeps its value and no busy period starts.
- R8: Levels 1, 2 and 3 protect the top quarter, the top half and the whole array. A write to a page inside the protected range is rejected as a whole, leaves the latch set and starts no busy period.
- R9: A committed status write copies data bit 7 to protect-enable and bits 3:2 to the protect level. It is refused when protect-enable is 1 and the protect pin `wp_n` is low.
- R10: A commit holds the status busy for exactly `WR_CYCLES` clock cycles, and the latch is clear when busy ends.
- R11: `tx_valid` is high only during a status read or the data phase of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_fall | input | 1 | One-cycle pulse: the device was selected |
| cs_rise | input | 1 | One-cycle pulse: the device was released |
| cs_aligned | input | 1 | Qualifies `cs_rise`: release came right after a whole byte |
| rx_valid | input | 1 | One-cycle pulse: `rx_byte` holds a received byte |
| rx_byte | input | 8 | Received byte, most significant bit first on the wire |
| tx_take | input | 1 | One-cycle pulse: the front end took `tx_byte` |
| wp_n | input | 1 | Hardware write-protect pin, active low |
| tx_valid | output | 1 | `tx_byte` is meaningful |
| tx_byte | output | 8 | Byte for the front end to shift out |

## Verification
Every input event is registered once, so a latch change, a status value or a new read byte is due at the sample point that follows the clock edge capturing the event, and the bench samples at the falling edge after that edge. The busy length is checked exactly: a status read started right after a commit lands its opcode four edges later, so the bench expects exactly `WR_CYCLES-4` samples of 0xFF before the real status appears. Read data is compared one byte per request, sampled before the request pulse moves the address on.

// File: rtl/eep_pkg.sv
package eep_pkg;

    typedef enum logic [2:0] {
        OP_WREN, OP_WRDI, OP_RDSR, OP_WRSR, OP_READ, OP_WRITE, OP_BAD
    } op_e;

    typedef enum logic [3:0] {
        S_OFF, S_OPC, S_AHI, S_ALO, S_RD, S_WR, S_SRW, S_RDSR, S_SKIP
    } state_e;

    typedef enum logic {
        PQ_ARRAY, PQ_STATUS
    } pq_e;

    typedef struct packed {
        logic       wpen;
        logic [1:0] bp;
        logic       wel;
    } sreg_t;

    // Bit 3 is don't-care; the upper nibble must be zero.
    function automatic op_e decode_op(input logic [7:0] b);
        if (b[7:4] != 4'h0) return OP_BAD;
        case (b[2:0])
            3'b110:  return OP_WREN;
            3'b100:  return OP_WRDI;
            3'b101:  return OP_RDSR;
            3'b001:  return OP_WRSR;
            3'b011:  return OP_READ;
            3'b010:  return OP_WRITE;
            default: return OP_BAD;
        endcase
    endfunction

    function automatic logic [7:0] status_byte(input sreg_t s, input logic busy);
        if (busy) return 8'hFF;
        return {s.wpen, 3'b000, s.bp, s.wel, 1'b0};
    endfunction

endpackage

// File: rtl/eep_prot.sv
module eep_prot
    import eep_pkg::*;
(
    input  pq_e        kind,
    input  logic [1:0] top_bits,
    input  logic [1:0] bp,
    input  logic       wpen,
    input  logic       wp_n,
    output logic       allow
);
    always_comb begin
        if (kind == PQ_STATUS) begin
            allow = !(wpen && !wp_n);
        end else begin
            case (bp)
                2'd0:    allow = 1'b1;
                2'd1:    allow = (top_bits != 2'b11);
                2'd2:    allow = !top_bits[1];
                default: allow = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/eep_array.sv
module eep_array #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/eep_pagebuf.sv
module eep_pagebuf #(
    parameter int PAGE_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              we,
    input  logic [PAGE_W-1:0] wcol,
    input  logic [7:0]        wdata,
    input  logic [PAGE_W-1:0] rcol,
    output logic [7:0]        rdata,
    output logic              rvalid
);
    localparam int PAGE_N = 1 << PAGE_W;

    logic [7:0]        buf_q [PAGE_N];
    logic [PAGE_N-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst || clr)  mask_q       <= '0;
        else if (we)     mask_q[wcol] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (we) buf_q[wcol] <= wdata;
    end

    assign rdata  = buf_q[rcol];
    assign rvalid = mask_q[rcol];
endmodule

// File: rtl/eep_cmd_engine.sv
module eep_cmd_engine
    import eep_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int PAGE_W    = 6,
    parameter int WR_CYCLES = 100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_fall,
    input  logic       cs_rise,
    input  logic       cs_aligned,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       tx_take,
    input  logic       wp_n,
    output logic       tx_valid,
    output logic [7:0] tx_byte
);
    localparam int HI_W  = ADDR_W - 8;
    localparam int PG_W  = ADDR_W - PAGE_W;
    localparam int CNT_W = $clog2(WR_CYCLES + 1);

    state_e             state;
    sreg_t              sreg;
    logic [CNT_W-1:0]   busy_cnt;
    logic               busy;
    logic [HI_W-1:0]    addr_hi;
    logic [ADDR_W-1:0]  cur_addr;
    logic [PAGE_W-1:0]  col;
    logic [PAGE_W-1:0]  wr_idx;
    logic               is_wr;
    logic               got_data;
    logic               sr_wpen;
    logic [1:0]         sr_bp;
    logic               wr_run;
    op_e                op;

    logic               cmd_cycle;
    logic               pb_clr, pb_we, pb_rvalid;
    logic [7:0]         pb_rdata;
    logic               arr_we;
    logic [7:0]         arr_rdata;
    pq_e                prot_kind;
    logic               allow;
    logic               commit;
    logic [PG_W-1:0]    page;

    assign op        = decode_op(rx_byte);
    assign busy      = (busy_cnt != '0);
    assign cmd_cycle = rx_valid && !cs_fall && !cs_rise;
    assign pb_we     = cmd_cycle && (state == S_WR);
    assign pb_clr    = cmd_cycle && (state == S_ALO) && is_wr;
    assign prot_kind = (state == S_SRW) ? PQ_STATUS : PQ_ARRAY;
    assign commit    = cs_rise && !cs_fall && cs_aligned && got_data && allow;
    assign page      = cur_addr[ADDR_W-1:PAGE_W];
    assign arr_we    = wr_run && pb_rvalid;

    eep_prot prot_i (
        .kind     (prot_kind),
        .top_bits (cur_addr[ADDR_W-1:ADDR_W-2]),
        .bp       (sreg.bp),
        .wpen     (sreg.wpen),
        .wp_n     (wp_n),
        .allow    (allow)
    );

    eep_pagebuf #(.PAGE_W(PAGE_W)) pbuf_i (
        .clk    (clk),
        .rst    (rst),
        .clr    (pb_clr),
        .we     (pb_we),
        .wcol   (col),
        .wdata  (rx_byte),
        .rcol   (wr_idx),
        .rdata  (pb_rdata),
        .rvalid (pb_rvalid)
    );

    eep_array #(.ADDR_W(ADDR_W)) arr_i (
        .clk   (clk),
        .we    (arr_we),
        .waddr ({page, wr_idx}),
        .wdata (pb_rdata),
        .raddr (cur_addr),
        .rdata (arr_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_OFF;
            sreg     <= '0;
            busy_cnt <= '0;
            addr_hi  <= '0;
            cur_addr <= '0;
            col      <= '0;
            wr_idx   <= '0;
            is_wr    <= 1'b0;
            got_data <= 1'b0;
            sr_wpen  <= 1'b0;
            sr_bp    <= '0;
            wr_run   <= 1'b0;
        end else begin
            // self-timed write cycle
            if (busy) begin
                busy_cnt <= busy_cnt - CNT_W'(1);
                if (busy_cnt == CNT_W'(1)) sreg.wel <= 1'b0;
            end
            // copy buffered page into the array, one column per cycle
            if (wr_run) begin
                wr_idx <= wr_idx + PAGE_W'(1);
                if (wr_idx == '1) wr_run <= 1'b0;
            end

            if (cs_fall) begin
                state    <= S_OPC;
                got_data <= 1'b0;
            end else if (cs_rise) begin
                state <= S_OFF;
                if (commit && state == S_WR) begin
                    busy_cnt <= CNT_W'(WR_CYCLES);
                    wr_run   <= 1'b1;
                    wr_idx   <= '0;
                end else if (commit && state == S_SRW) begin
                    busy_cnt  <= CNT_W'(WR_CYCLES);
                    sreg.wpen <= sr_wpen;
                    sreg.bp   <= sr_bp;
                end
            end else if (rx_valid) begin
                case (state)
                    S_OPC: begin
                        if (busy && op != OP_RDSR) begin
                            state <= S_SKIP;
                        end else begin
                            case (op)
                                OP_WREN:  begin sreg.wel <= 1'b1; state <= S_SKIP; end
                                OP_WRDI:  begin sreg.wel <= 1'b0; state <= S_SKIP; end
                                OP_RDSR:  state <= S_RDSR;
                                OP_WRSR:  state <= sreg.wel ? S_SRW : S_SKIP;
                                OP_READ:  begin is_wr <= 1'b0; state <= S_AHI; end
                                OP_WRITE: begin
                                    is_wr <= 1'b1;
                                    state <= sreg.wel ? S_AHI : S_SKIP;
                                end
                                default:  state <= S_SKIP;
                            endcase
                        end
                    end
                    S_AHI: begin
                        addr_hi <= rx_byte[HI_W-1:0];
                        state   <= S_ALO;
                    end
                    S_ALO: begin
                        cur_addr <= {addr_hi, rx_byte};
                        col      <= rx_byte[PAGE_W-1:0];
                        state    <= is_wr ? S_WR : S_RD;
                    end
                    S_WR: begin
                        col      <= col + PAGE_W'(1);
                        got_data <= 1'b1;
                    end
                    S_SRW: begin
                        sr_wpen  <= rx_byte[7];
                        sr_bp    <= rx_byte[3:2];
                        got_data <= 1'b1;
                    end
                    default: ;
                endcase
            end else if (tx_take && state == S_RD) begin
                cur_addr <= cur_addr + ADDR_W'(1);
            end
        end
    end

    assign tx_valid = (state == S_RDSR) || (state == S_RD);
    assign tx_byte  = (state == S_RDSR) ? status_byte(sreg, busy) : arr_rdata;

endmodule

// File: rtl/eep_cmd_engine_chk.sv
module eep_cmd_engine_chk #(
    parameter int WR_CYCLES = 100
) (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       wel,
    input logic       wpen,
    input logic [1:0] bp,
    input logic       rx_valid,
    input logic       tx_valid,
    input logic [7:0] tx_byte,
    input logic       arr_we
);
    int busy_run;

    always_ff @(posedge clk) begin
        if (rst)       busy_run <= 0;
        else if (busy) busy_run <= busy_run + 1;
        else           busy_run <= 0;
    end

    assert_busy_len_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (busy_run == WR_CYCLES));

    assert_wel_clear_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !wel);

    assert_busy_ff_R3: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && busy) |-> (tx_byte == 8'hFF));

    assert_wel_set_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(wel) |-> ($past(rx_valid) && !$past(busy)));

    assert_sreg_commit_R9: assert property (@(posedge clk) disable iff (rst)
        (!$stable(bp) || !$stable(wpen)) |-> $rose(busy));

    assert_array_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> busy);

endmodule

bind eep_cmd_engine eep_cmd_engine_chk #(.WR_CYCLES(WR_CYCLES)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .wel      (sreg.wel),
    .wpen     (sreg.wpen),
    .bp       (sreg.bp),
    .rx_valid (rx_valid),
    .tx_valid (tx_valid),
    .tx_byte  (tx_byte),
    .arr_we   (arr_we)
);

// File: tb/eep_cmd_engine_tb.sv
module eep_cmd_engine_tb_top;
    localparam int AW  = 10;
    localparam int WR  = 80;
    localparam int MSK = (1 << AW) - 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_fall = 1'b0, cs_rise = 1'b0, cs_aligned = 1'b0;
    logic       rx_valid = 1'b0, tx_take = 1'b0, wp_n = 1'b1;
    logic [7:0] rx_byte = 8'h00;
    logic       tx_valid;
    logic [7:0] tx_byte;

    int pass_n = 0;
    int fail_n = 0;

    logic [7:0] model [1 << AW];
    bit         known [1 << AW];
    logic [7:0] wdat  [128];

    always #10 clk = ~clk;

    eep_cmd_engine #(.ADDR_W(AW), .PAGE_W(6), .WR_CYCLES(WR)) dut_i (
        .clk(clk), .rst(rst), .cs_fall(cs_fall), .cs_rise(cs_rise),
        .cs_aligned(cs_aligned), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_take(tx_take), .wp_n(wp_n), .tx_valid(tx_valid), .tx_byte(tx_byte)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        if (act === exp) pass_n++;
        else begin
            fail_n++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic sel();
        @(negedge clk) cs_fall = 1'b1;
        @(negedge clk) cs_fall = 1'b0;
    endtask

    task automatic desel(input bit aligned);
        @(negedge clk) begin cs_rise = 1'b1; cs_aligned = aligned; end
        @(negedge clk) begin cs_rise = 1'b0; cs_aligned = 1'b0; end
    endtask

    task automatic sendb(input logic [7:0] b);
        @(negedge clk) begin rx_valid = 1'b1; rx_byte = b; end
        @(negedge clk) rx_valid = 1'b0;
    endtask

    task automatic one_op(input logic [7:0] opc);
        sel(); sendb(opc); desel(1'b1);
    endtask

    task automatic rdsr(output logic [7:0] v);
        sel(); sendb(8'h05); v = tx_byte; desel(1'b1);
    endtask

    task automatic poll_busy(output int n_ff);
        sel(); sendb(8'h05);
        n_ff = 0;
        while (tx_byte == 8'hFF && n_ff < 1000) begin
            n_ff++;
            @(negedge clk);
        end
        desel(1'b1);
    endtask

    task automatic wrsr(input logic [7:0] d);
        sel(); sendb(8'h01); sendb(d); desel(1'b1);
    endtask

    task automatic wr_page(input int a16, input int n, input bit aligned);
        sel(); sendb(8'h02); sendb(a16[15:8]); sendb(a16[7:0]);
        for (int i = 0; i < n; i++) sendb(wdat[i]);
        desel(aligned);
    endtask

    function automatic void model_write(input int a16, input int n);
        int base = (a16 & MSK) & ~63;
        int c    = a16 & 63;
        for (int i = 0; i < n; i++) begin
            model[base + ((c + i) % 64)] = wdat[i];
            known[base + ((c + i) % 64)] = 1'b1;
        end
    endfunction

    task automatic rd_check(input int a16, input int n, input string req);
        sel(); sendb(8'h03); sendb(a16[15:8]); sendb(a16[7:0]);
        for (int i = 0; i < n; i++) begin
            int ea = ((a16 & MSK) + i) & MSK;
            if (known[ea]) chk(req, {8'h00, tx_byte}, {8'h00, model[ea]});
            tx_take = 1'b1;
            @(negedge clk) tx_take = 1'b0;
        end
        desel(1'b1);
    endtask

    task automatic fill(input int n, input int seed_off);
        for (int i = 0; i < n; i++) wdat[i] = 8'(i * 7 + seed_off);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fail_n++;
        $display("FAIL watchdog all-R actual=timeout expected=finished");
        $display("%0d/%0d checks passed", pass_n, pass_n + fail_n);
        $finish;
    end

    initial begin
        logic [7:0] s;
        int nff;
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state
        chk("R11 idle tx_valid", {15'd0, tx_valid}, 16'd0);
        rdsr(s); chk("R2 reset status", {8'h00, s}, 16'h0000);

        // latch set/clear and bit-3 don't-care
        one_op(8'h06); rdsr(s); chk("R2 wren", {8'h00, s}, 16'h0002);
        one_op(8'h04); rdsr(s); chk("R2 wrdi", {8'h00, s}, 16'h0000);
        one_op(8'h0E); rdsr(s); chk("R1 wren bit3", {8'h00, s}, 16'h0002);
        one_op(8'h0C); rdsr(s); chk("R1 wrdi bit3", {8'h00, s}, 16'h0000);
        // invalid opcode swallows the rest of the select
        sel(); sendb(8'h16); sendb(8'h06); desel(1'b1);
        rdsr(s); chk("R1 bad opcode", {8'h00, s}, 16'h0000);

        // write without the latch
        fill(4, 1); wr_page(16'h0010, 4, 1'b1);
        rdsr(s); chk("R5 no-wel write", {8'h00, s}, 16'h0000);

        // basic page write with exact busy length
        one_op(8'h06);
        fill(8, 40);
        sel(); sendb(8'h02); sendb(8'h00); sendb(8'h08);
        for (int i = 0; i < 8; i++) sendb(wdat[i]);
        chk("R11 no tx in write", {15'd0, tx_valid}, 16'd0);
        desel(1'b1);
        model_write(16'h0008, 8);
        poll_busy(nff); chk("R10 busy length", 16'(nff), 16'(WR - 4));
        rdsr(s); chk("R10 wel cleared", {8'h00, s}, 16'h0000);
        rd_check(16'h0008, 8, "R6 basic write");
        fill(8, 99); wr_page(16'h0008, 8, 1'b1);
        rdsr(s); chk("R5 no-wel no busy", {8'h00, s}, 16'h0000);
        rd_check(16'h0008, 8, "R5 data kept");

        // high address bits ignored
        rd_check(16'hFC08, 4, "R4 high bits");

        // page wrap with 66 bytes from column 62
        one_op(8'h06); fill(66, 3); wr_page(16'h007E, 66, 1'b1);
        model_write(16'h007E, 66); poll_busy(nff);
        rd_check(16'h0040, 64, "R6 page wrap");

        // sequential read wraps to zero
        one_op(8'h06); fill(4, 11); wr_page(16'h0000, 4, 1'b1);
        model_write(16'h0000, 4); poll_busy(nff);
        one_op(8'h06); fill(2, 77); wr_page(16'h03FE, 2, 1'b1);
        model_write(16'h03FE, 2); poll_busy(nff);
        one_op(8'h06); fill(4, 55); wr_page(16'h0300, 4, 1'b1);
        model_write(16'h0300, 4); poll_busy(nff);
        rd_check(16'h03FE, 6, "R4 array wrap");

        // misaligned release and empty write
        one_op(8'h06); fill(3, 9); wr_page(16'h0100, 3, 1'b0);
        rdsr(s); chk("R7 misaligned", {8'h00, s}, 16'h0002);
        wr_page(16'h0100, 0, 1'b1);
        rdsr(s); chk("R7 no data", {8'h00, s}, 16'h0002);
        one_op(8'h04);

        // commands during busy
        one_op(8'h06); fill(4, 21); wr_page(16'h0180, 4, 1'b1);
        model_write(16'h0180, 4);
        rdsr(s); chk("R3 busy status", {8'h00, s}, 16'h00FF);
        wrsr(8'h8C);
        poll_busy(nff);
        rdsr(s); chk("R3 ignored in busy", {8'h00, s}, 16'h0000);

        // status write and protection levels
        one_op(8'h06); wrsr(8'h84); poll_busy(nff);
        rdsr(s); chk("R9 wrsr applied", {8'h00, s}, 16'h0084);
        one_op(8'h06); fill(2, 200); wr_page(16'h0300, 2, 1'b1);
        rdsr(s); chk("R8 quarter reject", {8'h00, s}, 16'h0086);
        rd_check(16'h0300, 4, "R8 quarter data kept");
        fill(2, 150); wr_page(16'h02C0, 2, 1'b1); model_write(16'h02C0, 2);
        poll_busy(nff);
        rd_check(16'h02C0, 2, "R8 below quarter");
        wp_n = 1'b0;
        one_op(8'h06); wrsr(8'h00);
        rdsr(s); chk("R9 pin blocks", {8'h00, s}, 16'h0086);
        wp_n = 1'b1;
        wrsr(8'h08); poll_busy(nff);
        rdsr(s); chk("R9 level two", {8'h00, s}, 16'h0008);
        one_op(8'h06); wr_page(16'h0200, 2, 1'b1);
        rdsr(s); chk("R8 half reject", {8'h00, s}, 16'h000A);
        wrsr(8'h0C); poll_busy(nff);
        one_op(8'h06); wr_page(16'h0000, 2, 1'b1);
        rdsr(s); chk("R8 all reject", {8'h00, s}, 16'h000E);
        rd_check(16'h0000, 4, "R8 all data kept");
        wrsr(8'h00); poll_busy(nff);
        rdsr(s); chk("R9 cleared", {8'h00, s}, 16'h0000);

        // random page writes
        for (int it = 0; it < 6; it++) begin
            int a = $urandom_range(0, MSK);
            int n = $urandom_range(1, 70);
            for (int i = 0; i < n; i++) wdat[i] = 8'($urandom);
            one_op(8'h06); wr_page(a, n, 1'b1); model_write(a, n);
            poll_busy(nff); chk("R10 random busy", 16'(nff), 16'(WR - 4));
            rd_check(a & ~63, 64, "R6 random page");
        end

        chk("R11 idle end", {15'd0, tx_valid}, 16'd0);
        $display("%0d/%0d checks passed", pass_n, pass_n + fail_n);
        $finish;
    end
endmodule